// File: doc/BRIEF.md
# Eight-Bit ALU with Condition Flags

This block is the execute stage of a small accumulator-style datapath. Each clock cycle in which `op_valid` is high, it reads an operation code, two byte operands, an extra high dividend byte and a three-bit bit selector. It writes the resulting byte and four condition flags into registers, and those registers are visible on the outputs after that same clock edge. The four flags are half-carry, negative, zero and carry. Each operation has its own rule for which flags it updates and how.

The operations are:
- add and subtract, each with or without the current carry;
- AND, OR and XOR;
- a single-bit test;
- rotates through the carry, plus logical and arithmetic shifts;
- direct set, clear and invert of the carry;
- a divide of a 16-bit dividend by an 8-bit divisor.

A divide that cannot complete (zero divisor, or a quotient wider than eight bits) is reported by setting the carry flag, and the result registers keep their previous contents. Operation codes (5 bits): 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 OR, 6 XOR, 7 bit test, 8 rotate right through carry, 9 rotate left through carry, 10 logical shift right, 11 shift left, 12 arithmetic shift right, 13 carry set, 14 carry clear, 15 carry invert, 16 divide. Codes 17 to 31 are unassigned.

Top module: `alu_cc_core`

## Requirements
- R1: A low `rst_n` at a clock edge clears `result`, `remainder` and all four flags to 0.
- R2: Code 0 gives `result` = (A+B) mod 256 and code 1 gives (A+B+C) mod 256. C becomes the carry out of bit 7 and H becomes the carry from bit 3 into bit 4. The outputs show this after the edge that samples the operation.
- R3: Code 2 gives `result` = (A-B) mod 256 and code 3 gives (A-B-C) mod 256. C becomes 1 exactly when A is less than B plus the borrow-in.
- R4: Every operation that writes `result` sets N to result bit 7 and sets Z to 1 exactly when the result is zero.
- R5: Codes 4, 5 and 6 give A AND B, A OR B and A XOR B. C and H are left unchanged.
- R6: H changes only on codes 0 and 1.
- R7: Code 7 copies bit `bit_sel` of A into C. `result`, N, Z and H are unchanged.
- R8: Code 8 shifts A right with the old C entering bit 7. Code 9 shifts A left with the old C entering bit 0. In both, C takes the bit shifted out.
- R9: Code 10 shifts right with a 0 fill, code 11 shifts left with a 0 fill, and code 12 shifts right keeping bit 7. In all three, C takes the bit shifted out.
- R10: Codes 13, 14 and 15 set C to 1, clear it, or invert it. `result`, N, Z and H are unchanged.
- R11: Code 16 divides {`divd_hi`, A} by B. When B is nonzero and `divd_hi` < B, `result` gets the quotient, `remainder` gets the remainder, and C is cleared.
- R12: On code 16 with B = 0 or `divd_hi` >= B, C is set. `result`, `remainder`, N, Z and H are unchanged.
- R13: With `op_valid` low, or with an unassigned code (17 to 31), no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 5 | Operation code |
| opnd_a | input | 8 | Operand A, low dividend byte |
| opnd_b | input | 8 | Operand B, divisor |
| divd_hi | input | 8 | High dividend byte |
| bit_sel | input | 3 | Bit index for the bit test |
| result | output | 8 | Registered result |
| remainder | output | 8 | Registered divide remainder |
| flag_h | output | 1 | Half-carry flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
Directed cases come first. Low-nibble overflow (0x0F+0x01) separates the half-carry from the main carry. 0xFF+0x01 exercises a zero result together with a carry. Subtracting with a borrow-in at A = B separates SBC from SUB. Divides with a zero divisor, with `divd_hi` = B, and with `divd_hi` = B-1 probe both sides of the overflow limit. Random operations then follow, with operands chosen so that divides succeed often, and with idle cycles and unassigned codes mixed in. This random sequence shows that the flags keep their stored values across operations that must not touch them.

// File: rtl/alu_cc_pkg.sv
// Package: shared operation encoding for the ALU with condition flags.
// Assumes a 5-bit operation code; values 17..31 are unassigned.
package alu_cc_pkg;
    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_ADDC  = 5'd1,
        OP_SUB   = 5'd2,
        OP_SUBC  = 5'd3,
        OP_AND   = 5'd4,
        OP_OR    = 5'd5,
        OP_XOR   = 5'd6,
        OP_BIT   = 5'd7,
        OP_ROR_C = 5'd8,
        OP_ROL_C = 5'd9,
        OP_SHR   = 5'd10,
        OP_SHL   = 5'd11,
        OP_ASR   = 5'd12,
        OP_CSET  = 5'd13,
        OP_CCLR  = 5'd14,
        OP_CINV  = 5'd15,
        OP_DIV   = 5'd16
    } alu_op_e;
endpackage

// File: rtl/alu_cc_addsub.sv
// Module: shared adder/subtractor with carry-in and half-carry.
// Assumes DATA_W is even; the half-carry is taken at the nibble midpoint.
// On subtract, cout is the borrow out of the top bit.
module alu_cc_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              sub,
    output logic [DATA_W-1:0] res,
    output logic              cout,
    output logic              half
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W:0] full;
    logic [HALF_W:0] low;

    // Full-width sum or difference, including the carry/borrow bit
    always_comb begin
        if (sub)
            full = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, cin};
        else
            full = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
    end

    // Low-half sum, used only to extract the carry into the upper half
    always_comb begin
        low = {1'b0, a[HALF_W-1:0]} + {1'b0, b[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
    end

    assign res  = full[DATA_W-1:0];
    assign cout = full[DATA_W];
    assign half = sub ? 1'b0 : low[HALF_W];
endmodule

// File: rtl/alu_cc_logic_shift.sv
// Module: bitwise logic plus shift and rotate unit.
// Assumes the caller routes only logic/shift codes here; other codes
// pass A through and keep the carry.
module alu_cc_logic_shift
    import alu_cc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    // Select the logic result or the shifted value and the bit shifted out
    always_comb begin
        res  = a;
        cout = cin;
        case (op)
            OP_AND:   res = a & b;
            OP_OR:    res = a | b;
            OP_XOR:   res = a ^ b;
            OP_ROR_C: begin res = {cin, a[DATA_W-1:1]};       cout = a[0];        end
            OP_ROL_C: begin res = {a[DATA_W-2:0], cin};       cout = a[DATA_W-1]; end
            OP_SHR:   begin res = {1'b0, a[DATA_W-1:1]};      cout = a[0];        end
            OP_SHL:   begin res = {a[DATA_W-2:0], 1'b0};      cout = a[DATA_W-1]; end
            OP_ASR:   begin res = {a[DATA_W-1], a[DATA_W-1:1]}; cout = a[0];      end
            default:  begin res = a; cout = cin; end
        endcase
    end
endmodule

// File: rtl/alu_cc_divider.sv
// Module: combinational restoring divider, 2*DATA_W by DATA_W.
// Assumes the quotient is valid only when err is low; err flags a zero
// divisor or a quotient that needs more than DATA_W bits.
module alu_cc_divider #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] dvd_hi,
    input  logic [DATA_W-1:0] dvd_lo,
    input  logic [DATA_W-1:0] dvs,
    output logic [DATA_W-1:0] quo,
    output logic [DATA_W-1:0] rem,
    output logic              err
);
    logic [DATA_W-1:0] part;
    logic [DATA_W:0]   trial;

    // Overflow test: quotient fits only when the high byte is below the divisor
    assign err = (dvs == '0) || (dvd_hi >= dvs);

    // One restoring step per quotient bit, most significant first
    always_comb begin
        part  = dvd_hi;
        quo   = '0;
        trial = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            trial = {part, dvd_lo[i]};
            if (trial >= {1'b0, dvs}) begin
                trial  = trial - {1'b0, dvs};
                quo[i] = 1'b1;
            end
            part = trial[DATA_W-1:0];
        end
        rem = part;
    end
endmodule

// File: rtl/alu_cc_core.sv
// Module: top of the ALU with condition flags.
// One operation per valid cycle; result, remainder and flags are
// registered and show the operation after the sampling edge.
// Assumes synchronous active-low reset.
module alu_cc_core
    import alu_cc_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] divd_hi,
    input  logic [SEL_W-1:0]  bit_sel,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] remainder,
    output logic              flag_h,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c
);
    alu_op_e op;
    assign op = alu_op_e'(op_code);

    logic              as_sub, as_cin, as_cout, as_half;
    logic [DATA_W-1:0] as_res;
    logic [DATA_W-1:0] ls_res;
    logic              ls_cout;
    logic [DATA_W-1:0] dv_quo, dv_rem;
    logic              dv_err;

    // Carry-in is used only by the with-carry forms
    assign as_sub = (op == OP_SUB) || (op == OP_SUBC);
    assign as_cin = ((op == OP_ADDC) || (op == OP_SUBC)) ? flag_c : 1'b0;

    alu_cc_addsub #(.DATA_W(DATA_W)) addsub_i (
        .a(opnd_a), .b(opnd_b), .cin(as_cin), .sub(as_sub),
        .res(as_res), .cout(as_cout), .half(as_half)
    );

    alu_cc_logic_shift #(.DATA_W(DATA_W)) lsu_i (
        .op(op), .a(opnd_a), .b(opnd_b), .cin(flag_c),
        .res(ls_res), .cout(ls_cout)
    );

    alu_cc_divider #(.DATA_W(DATA_W)) div_i (
        .dvd_hi(divd_hi), .dvd_lo(opnd_a), .dvs(opnd_b),
        .quo(dv_quo), .rem(dv_rem), .err(dv_err)
    );

    logic [DATA_W-1:0] nxt_res, nxt_rem;
    logic              nxt_h, nxt_n, nxt_z, nxt_c;
    logic              wr_res;

    // Per-operation next-state selection of result and flags
    always_comb begin
        nxt_res = result;
        nxt_rem = remainder;
        nxt_h   = flag_h;
        nxt_c   = flag_c;
        wr_res  = 1'b0;
        if (op_valid) begin
            case (op)
                OP_ADD, OP_ADDC: begin
                    nxt_res = as_res; nxt_c = as_cout; nxt_h = as_half; wr_res = 1'b1;
                end
                OP_SUB, OP_SUBC: begin
                    nxt_res = as_res; nxt_c = as_cout; wr_res = 1'b1;
                end
                OP_AND, OP_OR, OP_XOR: begin
                    nxt_res = ls_res; wr_res = 1'b1;
                end
                OP_ROR_C, OP_ROL_C, OP_SHR, OP_SHL, OP_ASR: begin
                    nxt_res = ls_res; nxt_c = ls_cout; wr_res = 1'b1;
                end
                OP_BIT:  nxt_c = opnd_a[bit_sel];
                OP_CSET: nxt_c = 1'b1;
                OP_CCLR: nxt_c = 1'b0;
                OP_CINV: nxt_c = ~flag_c;
                OP_DIV: begin
                    if (dv_err) begin
                        nxt_c = 1'b1;
                    end else begin
                        nxt_res = dv_quo; nxt_rem = dv_rem; nxt_c = 1'b0; wr_res = 1'b1;
                    end
                end
                default: wr_res = 1'b0;
            endcase
        end
    end

    // Sign and zero follow any newly written result, else hold
    always_comb begin
        nxt_n = wr_res ? nxt_res[DATA_W-1] : flag_n;
        nxt_z = wr_res ? (nxt_res == '0)   : flag_z;
    end

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            remainder <= '0;
            flag_h    <= 1'b0;
            flag_n    <= 1'b0;
            flag_z    <= 1'b0;
            flag_c    <= 1'b0;
        end else begin
            result    <= nxt_res;
            remainder <= nxt_rem;
            flag_h    <= nxt_h;
            flag_n    <= nxt_n;
            flag_z    <= nxt_z;
            flag_c    <= nxt_c;
        end
    end
endmodule

// File: rtl/alu_cc_core_chk.sv
// Module: property checker for alu_cc_core, attached by bind.
// Observes ports only; each property names its requirement.
module alu_cc_core_chk
    import alu_cc_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [OP_W-1:0]   op_code,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [DATA_W-1:0] divd_hi,
    input logic [SEL_W-1:0]  bit_sel,
    input logic [DATA_W-1:0] result,
    input logic [DATA_W-1:0] remainder,
    input logic              flag_h,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_c
);
    logic is_add, is_arith;
    assign is_add   = (op_code == OP_ADD) || (op_code == OP_ADDC);
    assign is_arith = is_add || (op_code == OP_SUB) || (op_code == OP_SUBC);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && remainder == '0 && !flag_h && !flag_n && !flag_z && !flag_c));

    assert_arith_nz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && is_arith |=> (flag_z == (result == '0)) && (flag_n == result[DATA_W-1]));

    assert_half_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && is_add) |=> $stable(flag_h));

    assert_bit_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == OP_BIT |=> (flag_c == $past(opnd_a[bit_sel])) && $stable(result));

    assert_carry_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == OP_CSET |=> flag_c && $stable(flag_n) && $stable(flag_z) && $stable(result));

    assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == OP_DIV && (opnd_b == '0 || divd_hi >= opnd_b)
        |=> flag_c && $stable(result) && $stable(remainder));

    assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable({result, remainder, flag_h, flag_n, flag_z, flag_c}));
endmodule

bind alu_cc_core alu_cc_core_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .divd_hi(divd_hi), .bit_sel(bit_sel),
    .result(result), .remainder(remainder), .flag_h(flag_h), .flag_n(flag_n),
    .flag_z(flag_z), .flag_c(flag_c)
);

// File: tb/alu_cc_core_tb_top.sv
// Bench: directed corner cases then seeded random operations, each
// compared with a bench model written from the requirements.
module alu_cc_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [4:0] op_code = '0;
    logic [7:0] opnd_a = '0, opnd_b = '0, divd_hi = '0;
    logic [2:0] bit_sel = '0;
    logic [7:0] result, remainder;
    logic       flag_h, flag_n, flag_z, flag_c;

    int checks = 0;
    int failures = 0;
    logic [19:0] mstate = '0;   // {result, remainder, h, n, z, c}

    always #2 clk = ~clk;

    alu_cc_core dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .divd_hi(divd_hi), .bit_sel(bit_sel),
        .result(result), .remainder(remainder), .flag_h(flag_h), .flag_n(flag_n),
        .flag_z(flag_z), .flag_c(flag_c)
    );

    // Bench model of one clock edge, derived from the requirements
    function automatic logic [19:0] model(logic [19:0] st, bit v, int op, int a, int b, int hi, int s);
        int r = st[19:12];
        int m = st[11:4];
        bit h = st[3], n = st[2], z = st[1], c = st[0];
        bit wr = 0;
        int dvd;
        if (v) begin
            case (op)
                0:  begin r = a + b;     h = (a % 16 + b % 16) > 15;     c = r > 255; wr = 1; end
                1:  begin r = a + b + c; h = (a % 16 + b % 16 + c) > 15; c = r > 255; wr = 1; end
                2:  begin c = a < b;     r = a - b;     wr = 1; end
                3:  begin r = a - b - c; c = a < b + c; wr = 1; end
                4:  begin r = a & b; wr = 1; end
                5:  begin r = a | b; wr = 1; end
                6:  begin r = a ^ b; wr = 1; end
                7:  c = (a >> s) & 1;
                8:  begin r = c * 128 + a / 2;     c = a % 2;  wr = 1; end
                9:  begin r = (a * 2) % 256 + c;   c = a / 128; wr = 1; end
                10: begin r = a / 2;               c = a % 2;  wr = 1; end
                11: begin r = (a * 2) % 256;       c = a / 128; wr = 1; end
                12: begin r = a / 2 + (a & 128);   c = a % 2;  wr = 1; end
                13: c = 1;
                14: c = 0;
                15: c = !c;
                16: begin
                    dvd = hi * 256 + a;
                    if (b == 0 || dvd / b > 255) c = 1;
                    else begin r = dvd / b; m = dvd % b; c = 0; wr = 1; end
                end
                default: ;
            endcase
        end
        r = r & 255;
        if (wr) begin n = r >= 128; z = (r == 0); end
        return {r[7:0], m[7:0], h, n, z, c};
    endfunction

    function automatic string tag_of(bit v, int op, int b, int hi);
        if (!v || op > 16) return "R13";
        case (op)
            0, 1: return "R2";
            2, 3: return "R3";
            4, 5, 6: return "R5";
            7: return "R7";
            8, 9: return "R8";
            10, 11, 12: return "R9";
            13, 14, 15: return "R10";
            default: return (b == 0 || hi >= b) ? "R12" : "R11";
        endcase
    endfunction

    task automatic compare(string tag);
        logic [19:0] act = {result, remainder, flag_h, flag_n, flag_z, flag_c};
        checks++;
        if (act !== mstate) begin
            failures++;
            $display("FAIL %s (flags R4 R6) actual=%h expected=%h", tag, act, mstate);
        end
    endtask

    task automatic do_op(bit v, int op, int a, int b, int hi, int s);
        @(negedge clk);
        op_valid = v; op_code = op[4:0]; opnd_a = a[7:0]; opnd_b = b[7:0];
        divd_hi = hi[7:0]; bit_sel = s[2:0];
        mstate = model(mstate, v, op, a, b, hi, s);
        @(posedge clk);
        #1;
        compare(tag_of(v, op, b, hi));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_valid = 1'b0;
        @(posedge clk);
        #1;
        mstate = '0;
        compare("R1");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        do_reset();
        // R2: half-carry without carry, then zero with carry
        do_op(1, 0, 8'h0F, 8'h01, 0, 0);
        do_op(1, 0, 8'hFF, 8'h01, 0, 0);
        do_op(1, 1, 8'h10, 8'h20, 0, 0);
        // R3: borrow, then borrow-in at equal operands
        do_op(1, 2, 8'h00, 8'h01, 0, 0);
        do_op(1, 3, 8'h40, 8'h40, 0, 0);
        // R7, R10 and R6 hold
        do_op(1, 7, 8'h80, 0, 0, 7);
        do_op(1, 7, 8'h80, 0, 0, 6);
        do_op(1, 13, 0, 0, 0, 0);
        do_op(1, 15, 0, 0, 0, 0);
        // R8, R9
        do_op(1, 13, 0, 0, 0, 0);
        do_op(1, 8, 8'h02, 0, 0, 0);
        do_op(1, 9, 8'h81, 0, 0, 0);
        do_op(1, 12, 8'h81, 0, 0, 0);
        do_op(1, 10, 8'h81, 0, 0, 0);
        do_op(1, 11, 8'hC0, 0, 0, 0);
        // R11, R12: divide limits
        do_op(1, 16, 8'h34, 8'h07, 8'h06, 0);
        do_op(1, 16, 8'h00, 8'h00, 8'h00, 0);
        do_op(1, 16, 8'h12, 8'h05, 8'h05, 0);
        do_op(1, 14, 0, 0, 0, 0);
        do_op(1, 16, 8'hFF, 8'hFF, 8'hFE, 0);
        // R13: idle and unassigned code
        do_op(0, 0, 8'h55, 8'h55, 0, 0);
        do_op(1, 21, 8'h55, 8'h55, 0, 0);
        do_reset();
        void'($urandom(32'd2024));
        for (int i = 0; i < 4000; i++) begin
            int op = $urandom % 20;
            int b = $urandom % 256;
            int hi = $urandom % 256;
            if (op == 16 && ($urandom % 4) != 0 && b != 0) hi = $urandom % b;
            do_op(($urandom % 8) != 0, op, $urandom % 256, b, hi, $urandom % 8);
        end
        do_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule